// File: doc/BRIEF.md
# Host-Bus Configuration Pin Bridge

This block sits on a 16-bit host processor bus and turns a small decoded address window into direct control of another device's configuration pins. Two write-only registers hold the levels driven onto the target: one carries the configuration clock and the configuration data, the other carries the active-low program (reset) pin and the active-low select and write strobes. A read-only register returns the target's status pins (init, done and busy) so that host software can poll them.

Nothing in the block sequences a configuration. The configuration clock is just a register bit, so software makes every rising and falling edge with its own writes. Each data bit or byte therefore costs one write that drops the clock and presents the data, then a second write that raises the clock. The status inputs are asynchronous to the bus clock and are synchronised before the host can read them.

A parameter selects the pin layout. In byte mode the target takes an 8-bit data bus and uses the select, write and busy pins. In serial mode it takes a single data pin, the select and write pins stay deasserted, and busy reads as zero.

Top module: `cfg_pin_bridge`

## Requirements
- R1: While reset is asserted, and right after it is released, tgtClk is 0, tgtData is 0, tgtProgN, tgtSelN and tgtWrN are 1, and busRdData is 0.
- R2: A write to word offset 0x0 loads the pin register. In byte mode the clock level comes from data bit 0 and the data byte from data bits 8:1. In serial mode the data pin comes from bit 0 and the clock from bit 1. The pins change at the clock edge that samples the write, and data bits above the layout are ignored.
- R3: A write to word offset 0x2 loads the strobe register. tgtProgN comes from bit 0, tgtWrN from bit 1 and tgtSelN from bit 2. The pins change at the sampling edge and higher bits are ignored.
- R4: A register loads only in a cycle where busCs and busWe are both 1. With either of them at 0, no output pin changes.
- R5: Address bit 0 takes no part in the decode, so offset 0x1 acts as 0x0, 0x3 as 0x2 and 0x5 as 0x4.
- R6: A write to offset 0x4, to offset 0x6, or to any address with a bit above bit 2 set, changes no output pin.
- R7: When busCs and busOe are 1 at offset 0x4, busRdData returns init in bit 0, done in bit 1 and busy in bit 2 (byte mode only), with all other bits 0. A change on a status pin reaches busRdData after exactly three rising clock edges.
- R8: busRdData is 0 for reads of offsets 0x0, 0x2 and 0x6, for any address with a bit above bit 2 set, and whenever busCs or busOe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W (24) | Host byte address |
| busWrData | input | 16 | Host write data |
| busCs | input | 1 | Chip select for the window, active high |
| busWe | input | 1 | Write enable, active high |
| busOe | input | 1 | Output enable for reads, active high |
| busRdData | output | 16 | Read data, zero when not selected |
| tgtClk | output | 1 | Configuration clock to the target |
| tgtData | output | 8 in byte mode, 1 in serial | Configuration data to the target |
| tgtProgN | output | 1 | Active-low program/reset pin |
| tgtSelN | output | 1 | Active-low select |
| tgtWrN | output | 1 | Active-low write strobe |
| tgtInit | input | 1 | Target init status |
| tgtDone | input | 1 | Target done status |
| tgtBusy | input | 1 | Target busy status (byte mode) |

## Verification
The hardest case to reach from the ports is the exact three-edge delay between a status pin and the value the host reads. The bench changes the status pins just after a falling edge, keeps a read of offset 0x4 open, and samples busRdData after the second and the third rising edge. It expects the old value after the second and the new value after the third. Aliased and out-of-window writes are mixed into a running write sequence, so every check that nothing changed compares the pins against a non-reset value that an earlier write set up.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
  // Word offsets, bits 2:1 of the address
  localparam logic [1:0] WSEL_PINS   = 2'd0;
  localparam logic [1:0] WSEL_STROBE = 2'd1;
  localparam logic [1:0] WSEL_STATUS = 2'd2;

  typedef struct packed {
    logic ldPins;
    logic ldStrobe;
    logic rdStatus;
  } strobe_t;
endpackage

// File: rtl/cpb_ctrl.sv
module cpb_ctrl
  import cpb_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busCs,
  input  logic              busWe,
  input  logic              busOe,
  output strobe_t           strb
);
  logic       inWindow;
  logic [1:0] wordSel;

  assign inWindow = (busAddr[ADDR_W-1:3] == '0);
  assign wordSel  = busAddr[2:1];

  always_comb begin
    strb          = '0;
    strb.ldPins   = busCs && busWe && inWindow && (wordSel == WSEL_PINS);
    strb.ldStrobe = busCs && busWe && inWindow && (wordSel == WSEL_STROBE);
    strb.rdStatus = busCs && busOe && inWindow && (wordSel == WSEL_STATUS);
  end

  // R4
  no_load_without_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busCs && busWe) |-> !strb.ldPins && !strb.ldStrobe);

  // R6
  status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[2:1] == 2'd2 || busAddr[2:1] == 2'd3) |-> !strb.ldPins && !strb.ldStrobe);
endmodule

// File: rtl/cpb_dp.sv
module cpb_dp
  import cpb_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit BYTE_MODE = 1'b1,
  parameter int PIN_W     = BYTE_MODE ? 8 : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              tgtClk,
  output logic [PIN_W-1:0]  tgtData,
  output logic              tgtProgN,
  output logic              tgtSelN,
  output logic              tgtWrN,
  input  logic              tgtInit,
  input  logic              tgtDone,
  input  logic              tgtBusy
);
  localparam int STAT_W = 3;

  logic [STAT_W-1:0] statRaw, syncA, syncB, statReg;

  // Pin register: layout picked by mode
  generate
    if (BYTE_MODE) begin : g_byte
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tgtClk  <= 1'b0;
          tgtData <= '0;
        end else if (strb.ldPins) begin
          tgtClk  <= busWrData[0];
          tgtData <= busWrData[PIN_W:1];
        end
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tgtProgN <= 1'b1;
          tgtWrN   <= 1'b1;
          tgtSelN  <= 1'b1;
        end else if (strb.ldStrobe) begin
          tgtProgN <= busWrData[0];
          tgtWrN   <= busWrData[1];
          tgtSelN  <= busWrData[2];
        end
      end
      assign statRaw = {tgtBusy, tgtDone, tgtInit};
    end else begin : g_serial
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tgtClk  <= 1'b0;
          tgtData <= '0;
        end else if (strb.ldPins) begin
          tgtData <= busWrData[0 +: PIN_W];
          tgtClk  <= busWrData[1];
        end
      end
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) tgtProgN <= 1'b1;
        else if (strb.ldStrobe) tgtProgN <= busWrData[0];
      end
      assign tgtWrN  = 1'b1;
      assign tgtSelN = 1'b1;
      assign statRaw = {1'b0 & tgtBusy, tgtDone, tgtInit};
    end
  endgenerate

  // Two-flop synchroniser, then the status register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      statReg <= '0;
    end else begin
      syncA   <= statRaw;
      syncB   <= syncA;
      statReg <= syncB;
    end
  end

  assign busRdData = strb.rdStatus ? {{(DATA_W-STAT_W){1'b0}}, statReg} : '0;

  // R2
  clk_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldPins |=> (tgtClk == (BYTE_MODE ? $past(busWrData[0]) : $past(busWrData[1]))));

  // R3
  prog_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldStrobe |=> (tgtProgN == $past(busWrData[0])));

  // R4
  pins_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldPins |=> $stable({tgtClk, tgtData}));

  // R4
  strobes_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldStrobe |=> $stable({tgtProgN, tgtSelN, tgtWrN}));

  // R8
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStatus |-> (busRdData == '0));
endmodule

// File: rtl/cfg_pin_bridge.sv
module cfg_pin_bridge
  import cpb_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter bit BYTE_MODE = 1'b1,
  parameter int PIN_W     = BYTE_MODE ? 8 : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busCs,
  input  logic              busWe,
  input  logic              busOe,
  output logic [DATA_W-1:0] busRdData,
  output logic              tgtClk,
  output logic [PIN_W-1:0]  tgtData,
  output logic              tgtProgN,
  output logic              tgtSelN,
  output logic              tgtWrN,
  input  logic              tgtInit,
  input  logic              tgtDone,
  input  logic              tgtBusy
);
  strobe_t strb;

  cpb_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .busCs(busCs), .busWe(busWe), .busOe(busOe), .strb(strb)
  );

  cpb_dp #(.DATA_W(DATA_W), .BYTE_MODE(BYTE_MODE), .PIN_W(PIN_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busWrData(busWrData), .busRdData(busRdData),
    .tgtClk(tgtClk), .tgtData(tgtData), .tgtProgN(tgtProgN),
    .tgtSelN(tgtSelN), .tgtWrN(tgtWrN),
    .tgtInit(tgtInit), .tgtDone(tgtDone), .tgtBusy(tgtBusy)
  );
endmodule

// File: tb/sim_cfg_pin_bridge.sv
module sim_cfg_pin_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] busAddr = '0;
  logic [15:0] busWrData = '0;
  logic        busCs = 1'b0, busWe = 1'b0, busOe = 1'b0;
  logic [15:0] busRdData;
  logic        tgtClk, tgtProgN, tgtSelN, tgtWrN;
  logic [7:0]  tgtData;
  logic        tgtInit = 1'b0, tgtDone = 1'b0, tgtBusy = 1'b0;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cfg_pin_bridge u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busCs(busCs), .busWe(busWe), .busOe(busOe), .busRdData(busRdData),
    .tgtClk(tgtClk), .tgtData(tgtData), .tgtProgN(tgtProgN),
    .tgtSelN(tgtSelN), .tgtWrN(tgtWrN),
    .tgtInit(tgtInit), .tgtDone(tgtDone), .tgtBusy(tgtBusy)
  );

  // Entry: addr, data, cs, we, exp clk, exp data, exp progN, exp wrN, exp selN
  localparam int NV = 13;
  localparam logic [53:0] VEC [NV] = '{
    {24'h000000, 16'h0003, 1'b1, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 1'b1}, // R2
    {24'h000000, 16'h01FE, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b1}, // R2
    {24'h000002, 16'h0000, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0}, // R3
    {24'h000000, 16'h0155, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0}, // R4
    {24'h000000, 16'h0155, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 1'b0}, // R4
    {24'h000001, 16'h0155, 1'b1, 1'b1, 1'b1, 8'hAA, 1'b0, 1'b0, 1'b0}, // R5
    {24'h000003, 16'h0005, 1'b1, 1'b1, 1'b1, 8'hAA, 1'b1, 1'b0, 1'b1}, // R5
    {24'h000004, 16'hFFFF, 1'b1, 1'b1, 1'b1, 8'hAA, 1'b1, 1'b0, 1'b1}, // R6
    {24'h000006, 16'h0000, 1'b1, 1'b1, 1'b1, 8'hAA, 1'b1, 1'b0, 1'b1}, // R6
    {24'h000008, 16'h0000, 1'b1, 1'b1, 1'b1, 8'hAA, 1'b1, 1'b0, 1'b1}, // R6
    {24'h800002, 16'h0007, 1'b1, 1'b1, 1'b1, 8'hAA, 1'b1, 1'b0, 1'b1}, // R6
    {24'h000002, 16'hFFF8, 1'b1, 1'b1, 1'b1, 8'hAA, 1'b0, 1'b0, 1'b0}, // R3
    {24'h000000, 16'hFE00, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}  // R2
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkPins(input string req, input logic [11:0] exp);
    logic [11:0] act;
    act = {tgtClk, tgtData, tgtProgN, tgtWrN, tgtSelN};
    chk(act === exp, req, {4'h0, act}, {4'h0, exp});
  endtask

  task automatic readAt(input logic [23:0] a, input bit cs, input bit oe);
    busAddr = a; busCs = cs; busOe = oe; busWe = 1'b0;
    #1;
  endtask

  initial begin
    @(negedge clk);
    // R1: in reset
    chkPins("R1", {1'b0, 8'h00, 3'b111});
    chk(busRdData === 16'h0, "R1", busRdData, 16'h0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chkPins("R1", {1'b0, 8'h00, 3'b111});

    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      v = VEC[i];
      busAddr = v[53:30]; busWrData = v[29:14]; busCs = v[13]; busWe = v[12];
      @(negedge clk);
      busCs = 1'b0; busWe = 1'b0;
      chkPins($sformatf("vector %0d R2/R3/R4/R5/R6", i), v[11:0]);
    end

    // R7: status latency of three edges
    readAt(24'h4, 1'b1, 1'b1);
    chk(busRdData === 16'h0, "R7", busRdData, 16'h0);
    tgtInit = 1'b1; tgtDone = 1'b0; tgtBusy = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(busRdData === 16'h0, "R7 two edges", busRdData, 16'h0);
    @(negedge clk);
    chk(busRdData === 16'h0005, "R7 three edges", busRdData, 16'h0005);
    tgtInit = 1'b0; tgtDone = 1'b1; tgtBusy = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk(busRdData === 16'h0002, "R7 done", busRdData, 16'h0002);
    readAt(24'h5, 1'b1, 1'b1);
    chk(busRdData === 16'h0002, "R5 read alias", busRdData, 16'h0002);

    // R8: other reads give zero
    readAt(24'h0, 1'b1, 1'b1);
    chk(busRdData === 16'h0, "R8 offset0", busRdData, 16'h0);
    readAt(24'h2, 1'b1, 1'b1);
    chk(busRdData === 16'h0, "R8 offset2", busRdData, 16'h0);
    readAt(24'h6, 1'b1, 1'b1);
    chk(busRdData === 16'h0, "R8 offset6", busRdData, 16'h0);
    readAt(24'hC, 1'b1, 1'b1);
    chk(busRdData === 16'h0, "R8 high bit", busRdData, 16'h0);
    readAt(24'h4, 1'b0, 1'b1);
    chk(busRdData === 16'h0, "R8 no cs", busRdData, 16'h0);
    readAt(24'h4, 1'b1, 1'b0);
    chk(busRdData === 16'h0, "R8 no oe", busRdData, 16'h0);

    // R1: reset mid-run restores safe levels
    busAddr = 24'h0; busWrData = 16'h01FF; busCs = 1'b1; busWe = 1'b1;
    @(negedge clk);
    busCs = 1'b0; busWe = 1'b0;
    rstN = 1'b0; #1;
    chkPins("R1 mid-run", {1'b0, 8'h00, 3'b111});
    readAt(24'h4, 1'b1, 1'b1);
    chk(busRdData === 16'h0, "R1 mid-run read", busRdData, 16'h0);
    @(negedge clk); rstN = 1'b1; busOe = 1'b0; busCs = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule